// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block produces consecutive entries of a polynomial table using nothing but adders. It keeps a chain of registers: the current table value, then one register per difference order, with the highest-order difference held constant. Before tabulating, the host writes the starting value and each starting difference through a simple load port that selects one register at a time.

Each accepted step pulse advances the table by one row. The differences cascade within the same cycle: the highest-order constant is added into the next-lower difference, that new difference is added into the one below it, and finally the fresh first difference is added into the value. One cycle after the step, the new value appears with a one-cycle valid flag and a row counter. All additions wrap at the register width, and a sticky flag records whether any adder in the chain ever carried out.

The default configuration handles quadratics (value plus two difference registers). The number of difference columns, the data width and the row-counter width are parameters.

Top module: `diff_tabulator`

## Requirements
- R1: A synchronous reset clears the value register, every difference register, the row counter, the valid flag and the overflow flag to zero.
- R2: With `load_en` high, `load_data` is written into the register chosen by `load_sel`: code 0 is the table value, code 1 the first difference, code 2 the second difference (default order 2); a code above the highest column writes nothing.
- R3: A load clears the row counter to zero, raises no valid, and when `step` is high in the same cycle the load wins and the step is discarded.
- R4: On an accepted step, each difference below the top is replaced by its old value plus the new value of the column above, and the value register then receives its old value plus the new first difference.
- R5: `out_valid` is high for exactly the cycle after each accepted step and low after any cycle with no accepted step.
- R6: `out_index` increases by one after each accepted step and wraps modulo 2^IDX_W.
- R7: Loaded with value 41, first difference 0 and second difference 2, four steps yield values 43, 47, 53 and 61 with row numbers 1 to 4.
- R8: All additions wrap modulo 2^WIDTH; `overflow` rises after a step in which any adder carries out and stays high until reset.
- R9: The highest-order difference never changes except through a load or reset.
- R10: `out_value` always shows the current value register, including directly after a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write strobe for the register chosen by `load_sel` |
| load_sel | input | SEL_W | Register select: 0 value, k the k-th difference |
| load_data | input | WIDTH | Data written on a load |
| step | input | 1 | Advance the table by one row |
| out_valid | output | 1 | One-cycle pulse after an accepted step |
| out_value | output | WIDTH | Current table value |
| out_index | output | IDX_W | Row number since the last load |
| overflow | output | 1 | Sticky flag, set by any adder carry-out |

## Verification
The assertions take for granted that `rst` is held high for at least one clock before any checked behaviour and that `load_sel` may carry any code, including ones above the highest column; they assume nothing about the overlap of `load_en` and `step`, so that collision is allowed freely. The stimulus mixes directed rows with a seeded random phase in which loads, steps, out-of-range selects and simultaneous load-and-step all occur, and large random loads drive the adders into carry-out so the sticky flag and wrap-around are exercised.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // Width of a select field able to name every column.
  function automatic int sel_width(input int ncol);
    return (ncol > 1) ? $clog2(ncol) : 1;
  endfunction

  // Column roles for the default quadratic configuration.
  typedef enum int {
    COL_VALUE = 0,
    COL_DIFF1 = 1,
    COL_DIFF2 = 2
  } col_role_e;

endpackage

// File: rtl/dt_load_decode.sv
module dt_load_decode #(
  parameter int NCOL  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [SEL_W-1:0] load_sel,
  output logic [NCOL-1:0]  load_hit
);

  // One strobe per column; codes beyond the last column hit nothing.
  always_comb begin
    for (int k = 0; k < NCOL; k++) begin
      load_hit[k] = load_en && (32'(load_sel) == k);
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_hit)); // R2
  AST_LOAD_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (load_en && (32'(load_sel) >= NCOL)) |-> (load_hit == '0)); // R2

endmodule

// File: rtl/dt_column.sv
module dt_column #(
  parameter int WIDTH  = 32,
  parameter bit IS_TOP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_go,
  input  logic             load_hit,
  input  logic [WIDTH-1:0] load_data,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             carry_out
);

  // Wrapping add with the carry exposed as the top bit.
  function automatic logic [WIDTH:0] add_carry(input logic [WIDTH-1:0] a,
                                               input logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  generate
    if (IS_TOP) begin : g_const
      // Highest-order difference is a constant of the polynomial.
      assign nxt       = cur;
      assign carry_out = 1'b0;
    end else begin : g_accum
      logic [WIDTH:0] sum;
      assign sum       = add_carry(cur, addend);
      assign nxt       = sum[WIDTH-1:0];
      assign carry_out = sum[WIDTH];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load_hit) begin
      cur <= load_data;
    end else if (step_go) begin
      cur <= nxt;
    end
  end

  AST_COL_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_hit |=> (cur == $past(load_data))); // R2

  generate
    if (IS_TOP) begin : g_top_chk
      AST_TOP_CONST: assert property (@(posedge clk) disable iff (rst)
        !load_hit |=> $stable(cur)); // R9
    end else begin : g_acc_chk
      AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_go && !load_hit) |=> (cur == WIDTH'($past(cur) + $past(addend)))); // R4
      AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_go && !load_hit) |=> $stable(cur)); // R3
    end
  endgenerate

endmodule

// File: rtl/dt_seq.sv
module dt_seq #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             step_go,
  input  logic             any_carry,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index,
  output logic             overflow
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_index <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= step_go;
      if (load_en) begin
        out_index <= '0;
      end else if (step_go) begin
        out_index <= out_index + 1'b1;
      end
      if (step_go && any_carry) begin
        overflow <= 1'b1;
      end
    end
  end

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    step_go |=> out_valid); // R5
  AST_VALID_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !step_go |=> !out_valid); // R5
  AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (!out_valid && out_index == '0)); // R3
  AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step_go |=> (out_index == IDX_W'($past(out_index) + 1'b1))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (step_go && any_carry) |=> overflow); // R8

endmodule

// File: rtl/diff_tabulator.sv
module diff_tabulator #(
  parameter int WIDTH = 32,
  parameter int ORDER = 2,
  parameter int IDX_W = 8,
  parameter int SEL_W = dt_pkg::sel_width(ORDER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [SEL_W-1:0] load_sel,
  input  logic [WIDTH-1:0] load_data,
  input  logic             step,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_value,
  output logic [IDX_W-1:0] out_index,
  output logic             overflow
);

  localparam int NCOL = ORDER + 1;

  // Named internal events, visible to the assertions.
  logic            step_go;
  logic [NCOL-1:0] load_hit;
  logic [NCOL-1:0] col_carry;
  logic            any_carry;

  // A load in the same cycle discards the step.
  assign step_go   = step && !load_en;
  assign any_carry = |col_carry;

  dt_load_decode #(
    .NCOL  (NCOL),
    .SEL_W (SEL_W)
  ) i_decode (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_sel (load_sel),
    .load_hit (load_hit)
  );

  // Column 0 is the value; column k the k-th difference. Each column adds
  // the freshly updated value of the column above it.
  generate
    for (genvar k = 0; k < NCOL; k++) begin : g_col
      logic [WIDTH-1:0] cur;
      logic [WIDTH-1:0] nxt;
      logic [WIDTH-1:0] addend;
      logic             carry;

      if (k == NCOL - 1) begin : g_top_src
        assign addend = '0;
      end else begin : g_chain_src
        assign addend = g_col[k+1].nxt;
      end

      dt_column #(
        .WIDTH  (WIDTH),
        .IS_TOP (k == NCOL - 1)
      ) i_col (
        .clk       (clk),
        .rst       (rst),
        .step_go   (step_go),
        .load_hit  (load_hit[k]),
        .load_data (load_data),
        .addend    (addend),
        .cur       (cur),
        .nxt       (nxt),
        .carry_out (carry)
      );

      assign col_carry[k] = carry;
    end
  endgenerate

  assign out_value = g_col[0].cur;

  dt_seq #(
    .IDX_W (IDX_W)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .step_go   (step_go),
    .any_carry (any_carry),
    .out_valid (out_valid),
    .out_index (out_index),
    .overflow  (overflow)
  );

  AST_VALUE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_en && 32'(load_sel) == 0) |=> (out_value == $past(load_data))); // R10
  AST_VALUE_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step) |=> $stable(out_value)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (out_value == '0 && !out_valid && out_index == '0 && !overflow)); // R1

endmodule

// File: tb/test_diff_tabulator.sv
module test_diff_tabulator;

  localparam int W  = 32;
  localparam int IW = 8;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_en;
  logic [SW-1:0] load_sel;
  logic [W-1:0]  load_data;
  logic          step;
  logic          out_valid;
  logic [W-1:0]  out_value;
  logic [IW-1:0] out_index;
  logic          overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of the table state.
  longint unsigned m_val, m_d1, m_d2;
  int unsigned     m_idx;
  bit              m_vld, m_ovf;

  always #10 clk = ~clk;

  diff_tabulator #(.WIDTH(W), .ORDER(2), .IDX_W(IW)) i_diff_tabulator (
    .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
    .load_data(load_data), .step(step), .out_valid(out_valid),
    .out_value(out_value), .out_index(out_index), .overflow(overflow)
  );

  function automatic longint unsigned mask_w(input longint unsigned x);
    return x & 64'h0000_0000_FFFF_FFFF;
  endfunction

  // Advance the model by one clock with the given inputs.
  task automatic model_clock(input bit ld, input int sel, input longint unsigned dat,
                             input bit st);
    longint unsigned s1, s0;
    if (ld) begin
      if (sel == 0) m_val = dat;
      else if (sel == 1) m_d1 = dat;
      else if (sel == 2) m_d2 = dat;
      m_idx = 0;
      m_vld = 1'b0;
    end else if (st) begin
      s1 = m_d1 + m_d2;
      s0 = m_val + mask_w(s1);
      if (s1 > 64'hFFFF_FFFF || s0 > 64'hFFFF_FFFF) m_ovf = 1'b1;
      m_d1  = mask_w(s1);
      m_val = mask_w(s0);
      m_idx = (m_idx + 1) % 256;
      m_vld = 1'b1;
    end else begin
      m_vld = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "out_value", out_value, m_val);
    check(tag, "out_valid", out_valid, m_vld);
    check(tag, "out_index", out_index, m_idx);
    check(tag, "overflow", overflow, m_ovf);
  endtask

  // Drive at the falling edge, clock once, compare at the next falling edge.
  task automatic cyc(input bit ld, input int sel, input longint unsigned dat,
                     input bit st, input string tag);
    load_en   = ld;
    load_sel  = SW'(sel);
    load_data = W'(dat);
    step      = st;
    @(posedge clk);
    model_clock(ld, sel, dat, st);
    @(negedge clk);
    load_en = 1'b0;
    step    = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0421;
    void'($urandom(seed));
    rst = 1'b1; load_en = 1'b0; load_sel = '0; load_data = '0; step = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_val = 0; m_d1 = 0; m_d2 = 0; m_idx = 0; m_vld = 0; m_ovf = 0;
    check_all("R1");

    // R2 R10: load the quadratic n*n+n+41.
    cyc(1'b1, 0, 41, 1'b0, "R10");
    cyc(1'b1, 1, 0, 1'b0, "R2");
    cyc(1'b1, 2, 2, 1'b0, "R2");
    // R7: fixed table rows.
    cyc(1'b0, 0, 0, 1'b1, "R7"); check("R7", "row1", out_value, 43);
    cyc(1'b0, 0, 0, 1'b1, "R7"); check("R7", "row2", out_value, 47);
    cyc(1'b0, 0, 0, 1'b1, "R7"); check("R7", "row3", out_value, 53);
    cyc(1'b0, 0, 0, 1'b1, "R7"); check("R7", "row4", out_value, 61);
    check("R6", "index after four steps", out_index, 4);
    // R5: idle cycle drops valid.
    cyc(1'b0, 0, 0, 1'b0, "R5");
    // R3: load beats step in the same cycle.
    cyc(1'b1, 0, 100, 1'b1, "R3");
    check("R3", "valid after collision", out_valid, 0);
    // R4 R9: d1 becomes 8+2=10, value 110.
    cyc(1'b0, 0, 0, 1'b1, "R4"); check("R4", "cascade", out_value, 110);
    cyc(1'b0, 0, 0, 1'b1, "R9"); check("R9", "constant top", out_value, 122);
    // R2: out-of-range select writes nothing.
    cyc(1'b1, 3, 999, 1'b0, "R2");
    cyc(1'b0, 0, 0, 1'b1, "R2"); check("R2", "after oor load", out_value, 136);
    // R8: wrap and sticky overflow.
    cyc(1'b1, 0, 64'hFFFF_FFFF, 1'b0, "R8");
    cyc(1'b1, 1, 0, 1'b0, "R8");
    cyc(1'b1, 2, 1, 1'b0, "R8");
    cyc(1'b0, 0, 0, 1'b1, "R8"); check("R8", "wrapped value", out_value, 0);
    check("R8", "overflow set", overflow, 1);
    cyc(1'b0, 0, 0, 1'b0, "R8"); check("R8", "overflow sticky", overflow, 1);

    // Reset again, then a random mix (R6 wrap comes from long step runs).
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_val = 0; m_d1 = 0; m_d2 = 0; m_idx = 0; m_vld = 0; m_ovf = 0;
    check_all("R1");
    cyc(1'b1, 0, 7, 1'b0, "R2");
    cyc(1'b1, 1, 3, 1'b0, "R2");
    cyc(1'b1, 2, 5, 1'b0, "R2");
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit ld, st;
      int sel;
      longint unsigned dat;
      r   = $urandom_range(0, 99);
      ld  = (r < 6);
      st  = ($urandom_range(0, 9) < 7);
      sel = $urandom_range(0, 3);
      dat = ($urandom_range(0, 3) == 0) ? longint'($urandom) : longint'($urandom_range(0, 50));
      cyc(ld, sel, dat, st, "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule